// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block turns a 22-bit word address on the external bus into one of four active-low chip selects: external RAM, ROM and two cartridge lines. A 12-bit configuration word controls the decode. It holds a RAM window code, a ROM/cartridge split mode, a three-way arbitration priority code, a wait-state count and a clock-output enable. Addresses below 0x4000 belong to on-chip resources and never produce an external select.

An access starts when `valid_i` is seen while the block is idle. The address and configuration are latched at that point. The matching select is then held low until the access ends, and `ready_o` pulses once after the programmed number of wait cycles. Separately, the block grants the bus to one of three requesters (CPU, video, audio) each cycle, in the order set by the priority code.

Top module: `ebus_csdec`

## Requirements
- R1: An access to a word address below 0x4000 drives no chip select; it still completes with `ready_o`.
- R2: When configuration bit 11 is 1, the RAM window is the top 4K·2^s words of the 22-bit space, with s = cfg[10:8]. Code 0 gives 4K words and code 7 gives 512K words, both ending at 0x3FFFFF. Addresses in the window drive `ram_cs_no` low.
- R3: When configuration bit 11 is 0, no address selects RAM, whatever the value of cfg[10:8].
- R4: With cfg[7:6] = 00, every external address outside the RAM window selects ROM.
- R5: With cfg[7:6] = 01, addresses 0x4000–0x1FFFFF select ROM and 0x200000–0x3FFFFF select cartridge line 1.
- R6: With cfg[7:6] = 10 or 11, the address ranges decode as follows: 0x4000–0x0FFFFF selects ROM, 0x100000–0x1FFFFF selects cartridge line 1, 0x200000–0x2FFFFF selects cartridge line 2, and 0x300000–0x3FFFFF selects cartridge line 1.
- R7: A RAM window hit takes precedence over every ROM or cartridge mapping.
- R8: At most one chip select is low at any time. All selects are high while no access is in progress. Selects go low in the cycle after the edge that samples `valid_i`.
- R9: With w = cfg[2:1], `ready_o` is high for exactly one cycle. That cycle is the (w+1)-th cycle after the edge that sampled `valid_i`. The access ends at the following edge.
- R10: `valid_i`, `addr_i` and `cfg_i` are ignored while an access is in progress. The selects stay those of the latched access.
- R11: `grant_o` is registered from `req_i`, with bit 0 = CPU, bit 1 = video and bit 2 = audio. It is one-hot, or zero when nothing requests. Priority code cfg[5:3] = 101 orders audio, video, CPU. Every other code, including 111, orders video, audio, CPU.
- R12: `clk_oe_o` follows cfg[0] one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 22 | Word address of the access |
| valid_i | input | 1 | Access request strobe |
| cfg_i | input | 12 | Bus configuration word |
| req_i | input | 3 | Bus requests: [0] CPU, [1] video, [2] audio |
| ram_cs_no | output | 1 | External RAM select, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| cart1_cs_no | output | 1 | Cartridge line 1 select, active low |
| cart2_cs_no | output | 1 | Cartridge line 2 select, active low |
| ready_o | output | 1 | End-of-access pulse after the wait states |
| grant_o | output | 3 | One-hot bus grant |
| clk_oe_o | output | 1 | Registered clock output enable |

## Verification
The selects are due one cycle after the edge that samples `valid_i`, and `ready_o` is due w cycles after that. The bench drives all inputs on falling edges. It reads the selects at the first falling edge after the sampling edge, then checks `ready_o` at each following falling edge. `ready_o` must be low until the w-th of these and high exactly there, and one falling edge later the selects must be high. Grant and clock enable are registered, so both are read at the falling edge after the one that drove the inputs.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef struct packed {
    logic       ram_en;
    logic [2:0] ram_sz;
    logic [1:0] rom_mode;
    logic [2:0] arb;
    logic [1:0] ws;
    logic       clk_oe;
  } cfg_t;

  typedef struct packed {
    logic ram;
    logic rom;
    logic cs1;
    logic cs2;
  } sel_t;

  localparam logic [1:0] ROM_FLAT = 2'b00;
  localparam logic [1:0] ROM_HALF = 2'b01;

  localparam logic [2:0] ARB_AUDIO_FIRST = 3'b101;

  localparam int unsigned REQ_CPU   = 0;
  localparam int unsigned REQ_VIDEO = 1;
  localparam int unsigned REQ_AUDIO = 2;
  localparam int unsigned N_REQ     = 3;

endpackage

// File: rtl/ebus_decode.sv
module ebus_decode
  import ebus_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 22,
  parameter logic [ADDR_W-1:0]  EXT_BASE   = 22'h004000,
  parameter int unsigned        RAM_MIN_LG = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_t              cfg_i,
  output sel_t              sel_o
);

  logic              ext;
  logic              ram_hit;
  logic [ADDR_W-1:0] low_mask;
  logic [1:0]        hi;
  sel_t              rom_sel;

  assign ext      = (addr_i >= EXT_BASE);
  assign low_mask = ~({ADDR_W{1'b1}} << (RAM_MIN_LG + int'(cfg_i.ram_sz)));
  assign ram_hit  = cfg_i.ram_en && (&(addr_i | low_mask));
  assign hi       = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    rom_sel = '0;
    if (cfg_i.rom_mode == ROM_FLAT) begin
      rom_sel.rom = 1'b1;
    end else if (cfg_i.rom_mode == ROM_HALF) begin
      if (hi[1]) rom_sel.cs1 = 1'b1;
      else       rom_sel.rom = 1'b1;
    end else begin
      case (hi)
        2'b00:   rom_sel.rom = 1'b1;
        2'b10:   rom_sel.cs2 = 1'b1;
        default: rom_sel.cs1 = 1'b1;
      endcase
    end
  end

  always_comb begin
    sel_o = '0;
    if (ext) begin
      if (ram_hit) sel_o.ram = 1'b1;  // RAM overrides split
      else         sel_o     = rom_sel;
    end
  end

endmodule

// File: rtl/ebus_access.sv
module ebus_access
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_t              cfg_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output cfg_t              cfg_q_o
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      addr_q_o <= '0;
      cfg_q_o  <= '0;
    end else if (!busy_o) begin
      if (valid_i) begin
        busy_o   <= 1'b1;
        cnt_q    <= cfg_i.ws;
        addr_q_o <= addr_i;
        cfg_q_o  <= cfg_i;
      end
    end else if (cnt_q == '0) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 2'd1;
    end
  end

  assign ready_o = busy_o && (cnt_q == '0);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ready_o) |=> (busy_o && $stable(addr_q_o) && $stable(cfg_q_o)));

  p_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !busy_o);

endmodule

// File: rtl/ebus_arb.sv
module ebus_arb
  import ebus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       arb_i,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] grant_o
);

  int unsigned       order [N_REQ];
  logic [N_REQ-1:0]  grant_d;
  logic              found;

  always_comb begin
    if (arb_i == ARB_AUDIO_FIRST) begin
      order[0] = REQ_AUDIO;
      order[1] = REQ_VIDEO;
    end else begin
      order[0] = REQ_VIDEO;
      order[1] = REQ_AUDIO;
    end
    order[2] = REQ_CPU;
  end

  always_comb begin
    grant_d = '0;
    found   = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (!found && req_i[order[i]]) begin
        grant_d[order[i]] = 1'b1;
        found             = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_o <= '0;
    else         grant_o <= grant_d;
  end

  p_grant_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_grant_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) != '0) |-> (grant_o != '0));

  p_grant_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~$past(req_i)) == '0));

endmodule

// File: rtl/ebus_csdec.sv
module ebus_csdec
  import ebus_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 22,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 22'h004000,
  parameter int unsigned       RAM_MIN_LG = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic [11:0]       cfg_i,
  input  logic [2:0]        req_i,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic              cart1_cs_no,
  output logic              cart2_cs_no,
  output logic              ready_o,
  output logic [2:0]        grant_o,
  output logic              clk_oe_o
);

  cfg_t              cfg;
  cfg_t              cfg_q;
  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  sel_t              sel;
  logic [3:0]        cs_n;

  assign cfg = cfg_t'(cfg_i);

  ebus_access #(.ADDR_W(ADDR_W)) u_access (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .addr_i   (addr_i),
    .cfg_i    (cfg),
    .busy_o   (busy),
    .ready_o  (ready_o),
    .addr_q_o (addr_q),
    .cfg_q_o  (cfg_q)
  );

  ebus_decode #(
    .ADDR_W     (ADDR_W),
    .EXT_BASE   (EXT_BASE),
    .RAM_MIN_LG (RAM_MIN_LG)
  ) u_decode (
    .addr_i (addr_q),
    .cfg_i  (cfg_q),
    .sel_o  (sel)
  );

  ebus_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arb_i   (cfg.arb),
    .req_i   (req_i),
    .grant_o (grant_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_oe_o <= 1'b0;
    else         clk_oe_o <= cfg.clk_oe;
  end

  assign cs_n        = ~({sel.ram, sel.rom, sel.cs1, sel.cs2} & {4{busy}});
  assign ram_cs_no   = cs_n[3];
  assign rom_cs_no   = cs_n[2];
  assign cart1_cs_no = cs_n[1];
  assign cart2_cs_no = cs_n[0];

  p_one_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{ram_cs_no, rom_cs_no, cart1_cs_no, cart2_cs_no}));

  p_idle_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (ram_cs_no && rom_cs_no && cart1_cs_no && cart2_cs_no));

  p_internal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (addr_q < EXT_BASE)) |-> (ram_cs_no && rom_cs_no && cart1_cs_no && cart2_cs_no));

  p_ready_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_ram_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no) |-> (cfg_q.ram_en && (rom_cs_no && cart1_cs_no && cart2_cs_no)));

endmodule

// File: tb/ebus_csdec_tb.sv
`timescale 1ns/1ps
module ebus_csdec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic        valid = 1'b0;
  logic [11:0] cfg = '0;
  logic [2:0]  req = '0;
  logic        ram_cs_n, rom_cs_n, c1_cs_n, c2_cs_n, ready, clk_oe;
  logic [2:0]  grant;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ebus_csdec dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .valid_i     (valid),
    .cfg_i       (cfg),
    .req_i       (req),
    .ram_cs_no   (ram_cs_n),
    .rom_cs_no   (rom_cs_n),
    .cart1_cs_no (c1_cs_n),
    .cart2_cs_no (c2_cs_n),
    .ready_o     (ready),
    .grant_o     (grant),
    .clk_oe_o    (clk_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // returns active-high {ram, rom, cs1, cs2}
  function automatic logic [3:0] exp_sel(input logic [21:0] a, input logic [11:0] c);
    logic [22:0] wsize;
    if (a < 22'h004000) return 4'b0000;
    wsize = 23'(4096) << c[10:8];
    if (c[11] && ({1'b0, a} >= (23'h400000 - wsize))) return 4'b1000;
    if (c[7:6] == 2'b00) return 4'b0100;
    if (c[7:6] == 2'b01) return (a < 22'h200000) ? 4'b0100 : 4'b0010;
    if (a < 22'h100000) return 4'b0100;
    if (a < 22'h200000) return 4'b0010;
    if (a < 22'h300000) return 4'b0001;
    return 4'b0010;
  endfunction

  function automatic string sel_tag(input logic [21:0] a, input logic [11:0] c);
    logic [22:0] wsize;
    wsize = 23'(4096) << c[10:8];
    if (a < 22'h004000) return "R1";
    if (c[11] && ({1'b0, a} >= (23'h400000 - wsize))) return "R2 R7";
    if (!c[11]) return "R3";
    if (c[7:6] == 2'b00) return "R4";
    if (c[7:6] == 2'b01) return "R5";
    return "R6";
  endfunction

  function automatic logic [2:0] exp_grant(input logic [2:0] code, input logic [2:0] r);
    if (code == 3'b101) begin
      if (r[2]) return 3'b100;
      if (r[1]) return 3'b010;
    end else begin
      if (r[1]) return 3'b010;
      if (r[2]) return 3'b100;
    end
    if (r[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [3:0] cs_vec();
    return ~{ram_cs_n, rom_cs_n, c1_cs_n, c2_cs_n};
  endfunction

  task automatic run_acc(input logic [21:0] a, input logic [11:0] c, input bit poke);
    logic [3:0] e;
    int w;
    string tg;
    e  = exp_sel(a, c);
    tg = sel_tag(a, c);
    w  = int'(c[2:1]);
    @(negedge clk);
    cfg = c; addr = a; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk({tg, " R8 select"}, 32'(cs_vec()), 32'(e));
    if (poke && w >= 2) begin
      valid = 1'b1; addr = ~a; cfg = c ^ 12'hFC0;
    end
    for (int k = 0; k <= w; k++) begin
      if (k > 0) begin
        @(negedge clk);
        if (k == 1) begin valid = 1'b0; cfg = c; addr = a; end
        if (poke && w >= 2) chk("R10 held select", 32'(cs_vec()), 32'(e));
      end
      chk("R9 ready timing", 32'(ready), 32'(k == w));
    end
    @(negedge clk);
    chk("R8 idle after access", 32'(cs_vec()), 32'h0);
    chk("R9 ready single", 32'(ready), 32'h0);
  endtask

  initial begin
    #(20ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [21:0] pts [26];
    pts[0] = 22'h000000; pts[1] = 22'h003FFF; pts[2] = 22'h004000;
    pts[3] = 22'h0FFFFF; pts[4] = 22'h100000; pts[5] = 22'h1FFFFF;
    pts[6] = 22'h200000; pts[7] = 22'h2FFFFF; pts[8] = 22'h300000;
    pts[9] = 22'h3FFFFF;
    for (int s = 0; s < 8; s++) begin
      pts[10 + 2*s] = 22'(23'h400000 - (23'(4096) << s));
      pts[11 + 2*s] = 22'(23'h400000 - (23'(4096) << s) - 23'd1);
    end

    repeat (3) @(negedge clk);
    chk("R8 reset selects", 32'(cs_vec()), 32'h0);
    chk("R9 reset ready", 32'(ready), 32'h0);
    chk("R11 reset grant", 32'(grant), 32'h0);
    rst_n = 1'b1;

    for (int rc = 0; rc < 16; rc++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int p = 0; p < 26; p++) begin
          logic [11:0] c;
          c = {4'(rc), 2'(rm), 3'b000, 2'((rc + rm + p) % 4), 1'b0};
          run_acc(pts[p], c, (p % 3) == 0);
        end
      end
    end

    for (int code = 0; code < 8; code++) begin
      for (int r = 0; r < 8; r++) begin
        @(negedge clk);
        cfg = {6'h0, 3'(code), 2'b00, 1'(r)};
        req = 3'(r);
        @(negedge clk);
        chk("R11 grant", 32'(grant), 32'(exp_grant(3'(code), 3'(r))));
        chk("R12 clock enable", 32'(clk_oe), 32'(r & 1));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule